// File: doc/BRIEF.md
# Protection Mode Supply Sequencer

This block decides when a switching regulator may switch its power transistor, when the high-voltage startup charger feeds the supply rail, and when the controller should fall back to a reduced operating current. It sees the supply rail only through five comparator flags: at or above the turn-on level (17 V), below the protected turn-off level (11 V), below the charger re-enable level (7 V), below the normal lockout level (6.5 V) and below the deep reset level (4 V). It also takes two qualified fault requests. An auto-restart fault causes a hiccup cycle. A latch fault keeps switching off until the rail collapses completely.

Without a fault, the block behaves as a plain under-voltage lockout. It switches from turn-on down to the normal lockout level. Once a fault is held, switching stops at once. The rail is then allowed to sag, and the reduced-current request is raised below the protected turn-off level to slow the discharge. The charger restarts below the re-enable level. An auto-restart fault is forgotten as the rail passes the protected level, so the next turn-on resumes switching. A latch fault survives every charger cycle and is dropped only below the deep reset level.

Top module: `psu_prot_seq`

## Requirements
- R1: After reset the charger is enabled and switching, the reduced-current request and both fault indications are off.
- R2: With no fault held, switching starts when the rail reaches the turn-on flag, and the charger is disabled at that moment.
- R3: With no fault held, switching continues while the rail is anywhere above the normal lockout level, including below 11 V and 7 V. It stops only below the normal lockout level, and the charger is then re-enabled.
- R4: A fault request that is accepted while switching stops switching within two clock cycles. Switching stays off while any fault is held.
- R5: After a fault has stopped switching, the reduced-current request is asserted while the rail is below the protected turn-off level and not yet below the re-enable level. It is low while the rail is still above the protected level.
- R6: After a fault shutdown, the charger is re-enabled (and the reduced-current request dropped) once the rail is below the re-enable level. If no latch fault is held, the next turn-on flag resumes switching.
- R7: A held auto-restart fault is cleared when the rail is below the protected turn-off level. Auto-restart requests that arrive while the rail is below that level are ignored.
- R8: With a latch fault held, reaching the turn-on flag disables the charger without starting switching. The charger is enabled again when the rail next falls below the re-enable level.
- R9: A held latch fault survives the rail falling below the re-enable and normal lockout levels. It is cleared only when the rail is below the deep reset level, after which the next turn-on resumes switching.
- R10: When latch and auto-restart requests arrive in the same cycle, only the latch fault is accepted.
- R11: A fault request of a single cycle is held until its own clear condition occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_at_on | input | 1 | Rail at or above turn-on level (17 V) |
| rail_lt_prot | input | 1 | Rail below protected turn-off level (11 V) |
| rail_lt_restart | input | 1 | Rail below charger re-enable level (7 V) |
| rail_lt_uvlo | input | 1 | Rail below normal lockout level (6.5 V) |
| rail_lt_reset | input | 1 | Rail below deep reset level (4 V) |
| ar_req | input | 1 | Qualified auto-restart fault request |
| latch_req | input | 1 | Qualified latch fault request |
| gate_en | output | 1 | Switching enable for the gate driver |
| charger_en | output | 1 | High-voltage startup charger enable |
| low_iq_req | output | 1 | Reduced operating current request |
| ar_fault | output | 1 | Auto-restart fault held |
| latch_fault | output | 1 | Latch fault held |

## Verification
The bench moves a modelled rail voltage through consistent flag sets and drives the fault requests as single-cycle pulses. A fault-free sweep from 17 V down through 11 V, 7 V and 6.6 V to 6.4 V separates the normal lockout from the protected one. The same sweep after an auto-restart pulse and after a latch pulse separates the two clear conditions: a resumed turn-on versus a charger-only turn-on. It also shows which intermediate levels must not clear a latch fault. Simultaneous requests, and requests made below 11 V, separate priority and ignore behaviour from plain stickiness.

// File: rtl/psu_prot_pkg.sv
// Shared types for the protection mode supply sequencer.
// Assumes: one clock domain, rail flags already synchronised upstream.
package psu_prot_pkg;

    // Sequencer states. Outputs are decoded from the state alone.
    typedef enum logic [1:0] {
        ST_CHARGE = 2'd0,   // charger on, no switching
        ST_RUN    = 2'd1,   // switching
        ST_HOLD   = 2'd2,   // fault stop, rail still above 11 V
        ST_SLOW   = 2'd3    // fault stop, rail below 11 V, reduced current
    } seq_state_t;

endpackage

// File: rtl/psu_fault_keeper.sv
// Holds accepted fault requests until their own clear condition occurs.
// Auto-restart clears below the protected turn-off level; latch clears
// below the deep reset level. A latch request wins over a simultaneous
// auto-restart request. Requests arriving during a clear level are dropped.
// Assumes: requests are already qualified (filtered) by the caller.
module psu_fault_keeper (
    input  logic clk,
    input  logic rst_n,
    input  logic ar_req,
    input  logic latch_req,
    input  logic clr_ar_lvl,
    input  logic clr_latch_lvl,
    output logic ar_hold,
    output logic latch_hold
);

    logic ar_take;

    // Auto-restart accepted only when no latch request competes.
    always_comb begin
        ar_take = ar_req & ~latch_req;
    end

    // Sticky fault registers with clear-dominant update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_hold    <= 1'b0;
            latch_hold <= 1'b0;
        end else begin
            ar_hold    <= clr_ar_lvl    ? 1'b0 : (ar_hold | ar_take);
            latch_hold <= clr_latch_lvl ? 1'b0 : (latch_hold | latch_req);
        end
    end

    // R7
    ar_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ar_lvl |=> !ar_hold);

    // R9
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_latch_lvl |=> !latch_hold);

    // R10
    latch_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_req && latch_req && !ar_hold && !clr_latch_lvl) |=> (latch_hold && !ar_hold));

    // R11
    latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_hold && !clr_latch_lvl) |=> latch_hold);

endmodule

// File: rtl/psu_seq_fsm.sv
// Supply sequencer state machine: normal lockout, fault hold, reduced
// current drain and charger cycling. All outputs are decoded from the
// registered state, so they change one clock after the deciding input.
// Assumes: rail flags are mutually consistent (a lower level implies the
// higher "below" flags) and fault holds come from psu_fault_keeper.
module psu_seq_fsm
    import psu_prot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rail_at_on,
    input  logic rail_lt_prot,
    input  logic rail_lt_restart,
    input  logic rail_lt_uvlo,
    input  logic fault_any,
    input  logic latch_hold,
    output logic gate_en,
    output logic charger_en,
    output logic low_iq_req
);

    seq_state_t state_q;
    seq_state_t state_d;

    // Next-state selection from rail flags and held faults.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CHARGE: begin
                if (rail_at_on) begin
                    state_d = latch_hold ? ST_HOLD : ST_RUN;
                end
            end
            ST_RUN: begin
                if (fault_any) begin
                    state_d = rail_lt_restart ? ST_CHARGE
                            : (rail_lt_prot ? ST_SLOW : ST_HOLD);
                end else if (rail_lt_uvlo) begin
                    state_d = ST_CHARGE;
                end
            end
            ST_HOLD: begin
                if (rail_lt_restart) begin
                    state_d = ST_CHARGE;
                end else if (rail_lt_prot) begin
                    state_d = ST_SLOW;
                end
            end
            ST_SLOW: begin
                if (rail_lt_restart) begin
                    state_d = ST_CHARGE;
                end
            end
            default: state_d = ST_CHARGE;
        endcase
    end

    // State register; reset starts charging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CHARGE;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore output decode.
    always_comb begin
        gate_en    = (state_q == ST_RUN);
        charger_en = (state_q == ST_CHARGE);
        low_iq_req = (state_q == ST_SLOW);
    end

    // R4
    fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && fault_any) |=> !gate_en);

    // R3
    uvlo_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && rail_lt_uvlo) |=> charger_en);

    // R8
    latch_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHARGE && latch_hold && rail_at_on) |=> (!gate_en && !charger_en));

    // R6
    recharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOW && rail_lt_restart) |=> (charger_en && !low_iq_req));

    // R3
    no_fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !fault_any && !rail_lt_uvlo) |=> gate_en);

endmodule

// File: rtl/psu_prot_seq.sv
// Top of the protection mode supply sequencer. Connects the fault keeper
// to the state machine and exposes the held fault flags.
// Assumes: all inputs synchronous to clk; rail flags from comparators
// with their own hysteresis.
module psu_prot_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_at_on,
    input  logic rail_lt_prot,
    input  logic rail_lt_restart,
    input  logic rail_lt_uvlo,
    input  logic rail_lt_reset,
    input  logic ar_req,
    input  logic latch_req,
    output logic gate_en,
    output logic charger_en,
    output logic low_iq_req,
    output logic ar_fault,
    output logic latch_fault
);

    logic ar_hold;
    logic latch_hold;
    logic fault_any;

    // Any held fault forces the protected behaviour.
    always_comb begin
        fault_any = ar_hold | latch_hold;
    end

    psu_fault_keeper u_keep (
        .clk           (clk),
        .rst_n         (rst_n),
        .ar_req        (ar_req),
        .latch_req     (latch_req),
        .clr_ar_lvl    (rail_lt_prot),
        .clr_latch_lvl (rail_lt_reset),
        .ar_hold       (ar_hold),
        .latch_hold    (latch_hold)
    );

    psu_seq_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .rail_at_on      (rail_at_on),
        .rail_lt_prot    (rail_lt_prot),
        .rail_lt_restart (rail_lt_restart),
        .rail_lt_uvlo    (rail_lt_uvlo),
        .fault_any       (fault_any),
        .latch_hold      (latch_hold),
        .gate_en         (gate_en),
        .charger_en      (charger_en),
        .low_iq_req      (low_iq_req)
    );

    // Fault flags are visible directly.
    always_comb begin
        ar_fault    = ar_hold;
        latch_fault = latch_hold;
    end

    // R1
    gate_charger_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_en && charger_en));

endmodule

// File: tb/tb_psu_prot_seq.sv
// Directed bench: a rail voltage model drives consistent flags; each task
// runs one scenario and checks its own results.
module tb_psu_prot_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rail_at_on = 1'b0;
    logic rail_lt_prot = 1'b1;
    logic rail_lt_restart = 1'b1;
    logic rail_lt_uvlo = 1'b1;
    logic rail_lt_reset = 1'b1;
    logic ar_req = 1'b0;
    logic latch_req = 1'b0;
    logic gate_en, charger_en, low_iq_req, ar_fault, latch_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    psu_prot_seq dut (
        .clk(clk), .rst_n(rst_n),
        .rail_at_on(rail_at_on), .rail_lt_prot(rail_lt_prot),
        .rail_lt_restart(rail_lt_restart), .rail_lt_uvlo(rail_lt_uvlo),
        .rail_lt_reset(rail_lt_reset), .ar_req(ar_req), .latch_req(latch_req),
        .gate_en(gate_en), .charger_en(charger_en), .low_iq_req(low_iq_req),
        .ar_fault(ar_fault), .latch_fault(latch_fault)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // Set rail level in millivolts and let the design settle.
    task automatic rail(input int mv);
        @(negedge clk);
        rail_at_on      = (mv >= 17000);
        rail_lt_prot    = (mv < 11000);
        rail_lt_restart = (mv < 7000);
        rail_lt_uvlo    = (mv < 6500);
        rail_lt_reset   = (mv < 4000);
        settle();
    endtask

    task automatic pulse(input logic a, input logic l);
        @(negedge clk);
        ar_req = a;
        latch_req = l;
        @(negedge clk);
        ar_req = 1'b0;
        latch_req = 1'b0;
    endtask

    task automatic t_reset();
        chk(charger_en, 1'b1, "R1 charger after reset");
        chk(gate_en, 1'b0, "R1 gate after reset");
        chk(low_iq_req, 1'b0, "R1 low current after reset");
        chk(ar_fault | latch_fault, 1'b0, "R1 faults after reset");
    endtask

    task automatic t_normal();
        rail(12000);
        chk(gate_en, 1'b0, "R2 no switching below turn-on");
        rail(17000);
        chk(gate_en, 1'b1, "R2 switching at turn-on");
        chk(charger_en, 1'b0, "R2 charger off at turn-on");
        rail(10000);
        chk(gate_en, 1'b1, "R3 switching at 10 V without fault");
        rail(6600);
        chk(gate_en, 1'b1, "R3 switching at 6.6 V without fault");
        chk(low_iq_req, 1'b0, "R3 no low current without fault");
        rail(6400);
        chk(gate_en, 1'b0, "R3 stop below lockout");
        chk(charger_en, 1'b1, "R3 charger after lockout");
    endtask

    task automatic t_auto_restart();
        rail(17000);
        rail(15000);
        pulse(1'b1, 1'b0);
        @(posedge clk); @(negedge clk);
        chk(gate_en, 1'b0, "R4 gate off two cycles after fault");
        chk(ar_fault, 1'b1, "R11 auto-restart fault held");
        settle();
        chk(low_iq_req, 1'b0, "R5 no low current above 11 V");
        chk(charger_en, 1'b0, "R5 charger off above 11 V");
        rail(10500);
        chk(low_iq_req, 1'b1, "R5 low current below 11 V");
        chk(ar_fault, 1'b0, "R7 auto-restart cleared below 11 V");
        chk(gate_en, 1'b0, "R4 gate stays off");
        pulse(1'b1, 1'b0);
        settle();
        chk(ar_fault, 1'b0, "R7 request below 11 V ignored");
        rail(6900);
        chk(charger_en, 1'b1, "R6 charger below 7 V");
        chk(low_iq_req, 1'b0, "R6 low current dropped below 7 V");
        rail(17000);
        chk(gate_en, 1'b1, "R6 switching resumes after auto-restart");
    endtask

    task automatic t_latch();
        rail(15000);
        pulse(1'b0, 1'b1);
        settle();
        chk(gate_en, 1'b0, "R4 gate off on latch fault");
        chk(latch_fault, 1'b1, "R11 latch fault held");
        rail(10000);
        chk(low_iq_req, 1'b1, "R5 low current in latch drain");
        rail(6800);
        chk(charger_en, 1'b1, "R8 charger below 7 V in latch");
        chk(latch_fault, 1'b1, "R9 latch kept at 6.8 V");
        rail(17000);
        chk(gate_en, 1'b0, "R8 no switching at turn-on in latch");
        chk(charger_en, 1'b0, "R8 charger off at turn-on in latch");
        rail(10000);
        rail(6800);
        chk(charger_en, 1'b1, "R8 charger cycles again");
        rail(5000);
        chk(latch_fault, 1'b1, "R9 latch kept at 5 V");
        rail(3900);
        chk(latch_fault, 1'b0, "R9 latch cleared below 4 V");
        rail(17000);
        chk(gate_en, 1'b1, "R9 switching after deep reset");
    endtask

    task automatic t_both();
        rail(15000);
        pulse(1'b1, 1'b1);
        settle();
        chk(latch_fault, 1'b1, "R10 latch accepted on tie");
        chk(ar_fault, 1'b0, "R10 auto-restart rejected on tie");
        chk(gate_en, 1'b0, "R10 gate off on tie");
        rail(3000);
        rail(17000);
        chk(gate_en, 1'b1, "R9 recovery after tie");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_normal();
        t_auto_restart();
        t_latch();
        t_both();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule